// File: doc/BRIEF.md
# Qualified Event Trigger with Ring-Buffer Pre/Post Capture

This block watches a stream of input samples, decides when an event has really happened, and freezes a window of samples around that event in an on-chip circular buffer. While armed it writes every valid sample into the ring. When a qualified trigger arrives, it keeps writing for a programmed post-event length, then stops writing so the block can be read out through a synchronous read port.

Five trigger conditions can be selected. Rising or falling edge detection uses a hysteresis band. Level detection is spaced out by a holdoff count. Window detection, for samples outside or inside a pair of limits, requires a dwell count before it fires. A software trigger request is also available. Each completed capture produces a descriptor holding the event timestamp, the trigger mode, the ring index of the first sample of the block, the pre-event and post-event lengths actually captured, the number of samples buffered at the event, and a flag that marks a short pre-event history.

Top module: `trig_capture`

## Requirements
- R1: After reset the block is idle: `desc_vld_o` is 0, nothing is written, and samples produce no descriptor until `arm_i` is pulsed while `cfg_err_o` is 0.
- R2: Mode 0 (rising edge) arms only when a valid sample satisfies sample + hysteresis < threshold. It fires on the first later valid sample that is >= threshold, and then disarms. Dips that do not go that deep never re-arm it.
- R3: Mode 1 (falling edge) mirrors R2. It arms when sample > threshold + hysteresis and fires on the first later valid sample that is <= threshold.
- R4: Mode 2 (level) fires on any valid sample that is >= threshold.
- R5: After a capture completes, triggers are ignored for the next `cfg_holdoff_i` valid samples. Triggers that occur during the post window are also ignored.
- R6: Mode 3 (window out) fires when a sample below `cfg_lo_i` or above `cfg_hi_i` is the `cfg_dwell_i`-th such sample in a row. A dwell of 0 acts as 1.
- R7: Mode 4 (window in) fires when a sample inside the inclusive limits [lo, hi] is the `cfg_dwell_i`-th such sample in a row.
- R8: Mode 5 (software) fires on the valid sample that arrives together with, or first after, a `sw_trig_i` pulse.
- R9: The captured block holds, in ring order starting at `desc_start_o`, the pre-event samples, then the triggering sample, then `post - 1` further samples. The triggering sample counts toward the post length.
- R10: The descriptor pre length is min(requested pre, samples written since arming before the event). `desc_short_o` is 1 exactly when that count is below the request, and `desc_fill_o` reports the count.
- R11: `cfg_err_o` is 1 when pre + post exceeds the ring depth or when post is 0. While it is 1, `arm_i` is refused.
- R12: `desc_vld_o` pulses for one cycle, in the cycle after the last post sample is clocked in. `desc_ts_o` and `desc_mode_o` hold the timestamp and mode of the triggering sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_vld_i | input | 1 | Sample valid |
| smp_i | input | DW | Unsigned sample value |
| ts_i | input | TSW | Free-running timestamp |
| arm_i | input | 1 | Start a new capture (accepted only when idle) |
| sw_trig_i | input | 1 | Software trigger request |
| cfg_mode_i | input | 3 | Trigger mode, 0 to 5 as in R2 to R8 |
| cfg_thr_i | input | DW | Edge or level threshold |
| cfg_hyst_i | input | DW | Edge hysteresis |
| cfg_lo_i | input | DW | Window lower limit |
| cfg_hi_i | input | DW | Window upper limit |
| cfg_dwell_i | input | CW | Window dwell count |
| cfg_holdoff_i | input | CW | Holdoff, in samples |
| cfg_pre_i | input | AW+1 | Requested pre-event samples |
| cfg_post_i | input | AW+1 | Post-event samples, trigger included |
| rd_addr_i | input | AW | Ring read address |
| rd_data_o | output | DW | Ring read data, one cycle after the address |
| cfg_err_o | output | 1 | Illegal length configuration |
| desc_vld_o | output | 1 | Descriptor valid pulse |
| desc_ts_o | output | TSW | Timestamp of the triggering sample |
| desc_mode_o | output | 3 | Mode that fired |
| desc_start_o | output | AW | Ring index of the first sample of the block |
| desc_pre_o | output | AW+1 | Pre-event samples captured |
| desc_post_o | output | AW+1 | Post-event samples captured |
| desc_fill_o | output | AW+1 | Samples buffered since arming at the event |
| desc_short_o | output | 1 | Pre-event history shorter than requested |

## Verification
The assertions assume that configuration inputs stay constant while a capture is armed or running. They also assume that `rd_addr_i` is used only while idle, so no read collides with a write. The stimulus sets each configuration before pulsing `arm_i`, and it reads the ring only after the descriptor pulse. Each trigger scenario begins from a reset, so edge arming and dwell counts start from a known state. Samples are always presented with `smp_vld_i` high for exactly one clock.

// File: rtl/trig_pkg.sv
package trig_pkg;
  typedef enum logic [2:0] {
    TM_RISE  = 3'd0,
    TM_FALL  = 3'd1,
    TM_LEVEL = 3'd2,
    TM_WOUT  = 3'd3,
    TM_WIN   = 3'd4,
    TM_SOFT  = 3'd5
  } trig_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARMED,
    ST_POST
  } cap_state_e;
endpackage

// File: rtl/trig_detect.sv
module trig_detect import trig_pkg::*; #(
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vld_i,
  input  logic [DW-1:0] smp_i,
  input  logic [2:0]    mode_i,
  input  logic [DW-1:0] thr_i,
  input  logic [DW-1:0] hyst_i,
  input  logic [DW-1:0] lo_i,
  input  logic [DW-1:0] hi_i,
  input  logic [CW-1:0] dwell_i,
  input  logic          sw_i,
  output logic          hit_o
);
  logic          armed_q, sw_pend_q;
  logic [CW-1:0] dwell_cnt_q;
  logic          rise_arm, fall_arm, arm_cond, edge_hit;
  logic          outside, win_cond, win_hit;
  logic [CW-1:0] dwell_eff;

  assign rise_arm = ({1'b0, smp_i} + {1'b0, hyst_i}) < {1'b0, thr_i};
  assign fall_arm = {1'b0, smp_i} > ({1'b0, thr_i} + {1'b0, hyst_i});
  assign arm_cond = (mode_i == TM_FALL) ? fall_arm : rise_arm;
  assign edge_hit = armed_q && ((mode_i == TM_FALL) ? (smp_i <= thr_i) : (smp_i >= thr_i));

  assign outside   = (smp_i < lo_i) || (smp_i > hi_i);
  assign win_cond  = (mode_i == TM_WOUT) ? outside : !outside;
  assign dwell_eff = (dwell_i == '0) ? CW'(1) : dwell_i;
  assign win_hit   = win_cond && (({1'b0, dwell_cnt_q} + (CW+1)'(1)) >= {1'b0, dwell_eff});

  always_comb begin
    hit_o = 1'b0;
    if (vld_i) begin
      unique case (mode_i)
        TM_RISE, TM_FALL: hit_o = edge_hit;
        TM_LEVEL:         hit_o = smp_i >= thr_i;
        TM_WOUT, TM_WIN:  hit_o = win_hit;
        TM_SOFT:          hit_o = sw_i || sw_pend_q;
        default:          hit_o = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q     <= 1'b0;
      dwell_cnt_q <= '0;
      sw_pend_q   <= 1'b0;
    end else begin
      sw_pend_q <= vld_i ? 1'b0 : (sw_pend_q || sw_i);
      if (vld_i) begin
        if (edge_hit)      armed_q <= 1'b0;
        else if (arm_cond) armed_q <= 1'b1;
        if (!win_cond)                 dwell_cnt_q <= '0;
        else if (dwell_cnt_q != '1)    dwell_cnt_q <= dwell_cnt_q + CW'(1);
      end
    end
  end

  // an edge fire consumes the arming
  p_edge_disarm_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && (mode_i == TM_RISE || mode_i == TM_FALL)) |=> !armed_q);

  // a window fire with dwell above one needs prior in-condition history
  p_dwell_hist_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && (mode_i == TM_WOUT || mode_i == TM_WIN) && dwell_i > CW'(1)) |-> dwell_cnt_q != '0);
endmodule

// File: rtl/trig_ring.sv
module trig_ring #(
  parameter int DW = 16,
  parameter int AW = 10
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [DW-1:0] wd_i,
  input  logic [AW-1:0] ra_i,
  output logic [DW-1:0] rd_o
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[wa_i] <= wd_i;
    rd_o <= mem_q[ra_i];
  end
endmodule

// File: rtl/trig_seq.sv
module trig_seq import trig_pkg::*; #(
  parameter int AW  = 10,
  parameter int CW  = 16,
  parameter int TSW = 32,
  localparam int LW = AW + 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           vld_i,
  input  logic           hit_i,
  input  logic           arm_i,
  input  logic [2:0]     mode_i,
  input  logic [LW-1:0]  pre_i,
  input  logic [LW-1:0]  post_i,
  input  logic [CW-1:0]  holdoff_i,
  input  logic [TSW-1:0] ts_i,
  output logic           cfg_err_o,
  output logic           wr_en_o,
  output logic [AW-1:0]  wr_addr_o,
  output logic           desc_vld_o,
  output logic [TSW-1:0] desc_ts_o,
  output logic [2:0]     desc_mode_o,
  output logic [AW-1:0]  desc_start_o,
  output logic [LW-1:0]  desc_pre_o,
  output logic [LW-1:0]  desc_post_o,
  output logic [LW-1:0]  desc_fill_o,
  output logic           desc_short_o
);
  localparam int DEPTH = 1 << AW;

  cap_state_e    state_q;
  logic [AW-1:0] wr_ptr_q;
  logic [LW-1:0] fill_q, left_q, pre_act;
  logic [CW-1:0] hold_q;
  logic          accept;

  assign cfg_err_o = (({1'b0, pre_i} + {1'b0, post_i}) > (LW+1)'(DEPTH)) || (post_i == '0);
  assign wr_en_o   = vld_i && (state_q != ST_IDLE);
  assign wr_addr_o = wr_ptr_q;
  assign accept    = hit_i && (hold_q == '0);
  assign pre_act   = (fill_q < pre_i) ? fill_q : pre_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      wr_ptr_q     <= '0;
      fill_q       <= '0;
      left_q       <= '0;
      hold_q       <= '0;
      desc_vld_o   <= 1'b0;
      desc_ts_o    <= '0;
      desc_mode_o  <= '0;
      desc_start_o <= '0;
      desc_pre_o   <= '0;
      desc_post_o  <= '0;
      desc_fill_o  <= '0;
      desc_short_o <= 1'b0;
    end else begin
      desc_vld_o <= 1'b0;
      if (vld_i && hold_q != '0) hold_q <= hold_q - CW'(1);
      if (wr_en_o) wr_ptr_q <= wr_ptr_q + AW'(1);
      unique case (state_q)
        ST_IDLE: if (arm_i && !cfg_err_o) begin
          state_q <= ST_ARMED;
          fill_q  <= '0;
        end
        ST_ARMED: if (vld_i) begin
          if (accept) begin
            desc_ts_o    <= ts_i;
            desc_mode_o  <= mode_i;
            desc_start_o <= wr_ptr_q - pre_act[AW-1:0];
            desc_pre_o   <= pre_act;
            desc_post_o  <= post_i;
            desc_fill_o  <= fill_q;
            desc_short_o <= fill_q < pre_i;
            if (post_i == LW'(1)) begin
              state_q    <= ST_IDLE;
              desc_vld_o <= 1'b1;
              hold_q     <= holdoff_i;
            end else begin
              state_q <= ST_POST;
              left_q  <= post_i - LW'(1);
            end
          end else if (fill_q != LW'(DEPTH)) begin
            fill_q <= fill_q + LW'(1);
          end
        end
        ST_POST: if (vld_i) begin
          if (left_q == LW'(1)) begin
            state_q    <= ST_IDLE;
            desc_vld_o <= 1'b1;
            hold_q     <= holdoff_i;
          end else begin
            left_q <= left_q - LW'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_desc_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_vld_o |=> !desc_vld_o);

  p_holdoff_block_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ARMED && hit_i && hold_q != '0) |=> state_q == ST_ARMED);

  p_err_no_arm_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && cfg_err_o) |=> state_q == ST_IDLE);

  p_short_pre_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_vld_o |-> (desc_short_o ? (desc_pre_o == desc_fill_o) : (desc_pre_o <= desc_fill_o)));

  p_block_fits_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_vld_o |-> ({1'b0, desc_pre_o} + {1'b0, desc_post_o}) <= (LW+1)'(DEPTH));
endmodule

// File: rtl/trig_capture.sv
module trig_capture import trig_pkg::*; #(
  parameter int DW    = 16,
  parameter int TSW   = 32,
  parameter int DEPTH = 1024,
  parameter int CW    = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           smp_vld_i,
  input  logic [DW-1:0]  smp_i,
  input  logic [TSW-1:0] ts_i,
  input  logic           arm_i,
  input  logic           sw_trig_i,
  input  logic [2:0]     cfg_mode_i,
  input  logic [DW-1:0]  cfg_thr_i,
  input  logic [DW-1:0]  cfg_hyst_i,
  input  logic [DW-1:0]  cfg_lo_i,
  input  logic [DW-1:0]  cfg_hi_i,
  input  logic [CW-1:0]  cfg_dwell_i,
  input  logic [CW-1:0]  cfg_holdoff_i,
  input  logic [LW-1:0]  cfg_pre_i,
  input  logic [LW-1:0]  cfg_post_i,
  input  logic [AW-1:0]  rd_addr_i,
  output logic [DW-1:0]  rd_data_o,
  output logic           cfg_err_o,
  output logic           desc_vld_o,
  output logic [TSW-1:0] desc_ts_o,
  output logic [2:0]     desc_mode_o,
  output logic [AW-1:0]  desc_start_o,
  output logic [LW-1:0]  desc_pre_o,
  output logic [LW-1:0]  desc_post_o,
  output logic [LW-1:0]  desc_fill_o,
  output logic           desc_short_o
);
  logic          hit, wr_en;
  logic [AW-1:0] wr_addr;

  trig_detect #(.DW(DW), .CW(CW)) u_detect (
    .clk_i, .rst_ni,
    .vld_i   (smp_vld_i),
    .smp_i,
    .mode_i  (cfg_mode_i),
    .thr_i   (cfg_thr_i),
    .hyst_i  (cfg_hyst_i),
    .lo_i    (cfg_lo_i),
    .hi_i    (cfg_hi_i),
    .dwell_i (cfg_dwell_i),
    .sw_i    (sw_trig_i),
    .hit_o   (hit)
  );

  trig_seq #(.AW(AW), .CW(CW), .TSW(TSW)) u_seq (
    .clk_i, .rst_ni,
    .vld_i     (smp_vld_i),
    .hit_i     (hit),
    .arm_i,
    .mode_i    (cfg_mode_i),
    .pre_i     (cfg_pre_i),
    .post_i    (cfg_post_i),
    .holdoff_i (cfg_holdoff_i),
    .ts_i,
    .cfg_err_o,
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .desc_vld_o, .desc_ts_o, .desc_mode_o, .desc_start_o,
    .desc_pre_o, .desc_post_o, .desc_fill_o, .desc_short_o
  );

  trig_ring #(.DW(DW), .AW(AW)) u_ring (
    .clk_i,
    .we_i (wr_en),
    .wa_i (wr_addr),
    .wd_i (smp_i),
    .ra_i (rd_addr_i),
    .rd_o (rd_data_o)
  );
endmodule

// File: tb/trig_capture_test.sv
`timescale 1ns/1ps
module trig_capture_test;
  localparam int DW = 16, TSW = 32, DEPTH = 1024, CW = 16;
  localparam int AW = $clog2(DEPTH), LW = AW + 1;

  logic           clk = 1'b0, rst_ni = 1'b0;
  logic           smp_vld = 1'b0, arm = 1'b0, sw_trig = 1'b0;
  logic [DW-1:0]  smp = '0, thr = '0, hyst = '0, lo = '0, hi = '0;
  logic [TSW-1:0] ts = '0;
  logic [2:0]     mode = '0;
  logic [CW-1:0]  dwell = '0, holdoff = '0;
  logic [LW-1:0]  pre = LW'(2), post = LW'(1);
  logic [AW-1:0]  rd_addr = '0;
  logic [DW-1:0]  rd_data;
  logic           cfg_err, desc_vld, desc_short;
  logic [TSW-1:0] desc_ts;
  logic [2:0]     desc_mode;
  logic [AW-1:0]  desc_start;
  logic [LW-1:0]  desc_pre, desc_post, desc_fill;

  int n_chk = 0, n_fail = 0, pulses = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  trig_capture #(.DW(DW), .TSW(TSW), .DEPTH(DEPTH), .CW(CW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .smp_vld_i(smp_vld), .smp_i(smp), .ts_i(ts),
    .arm_i(arm), .sw_trig_i(sw_trig), .cfg_mode_i(mode), .cfg_thr_i(thr),
    .cfg_hyst_i(hyst), .cfg_lo_i(lo), .cfg_hi_i(hi), .cfg_dwell_i(dwell),
    .cfg_holdoff_i(holdoff), .cfg_pre_i(pre), .cfg_post_i(post),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .cfg_err_o(cfg_err),
    .desc_vld_o(desc_vld), .desc_ts_o(desc_ts), .desc_mode_o(desc_mode),
    .desc_start_o(desc_start), .desc_pre_o(desc_pre), .desc_post_o(desc_post),
    .desc_fill_o(desc_fill), .desc_short_o(desc_short)
  );

  always @(negedge clk) if (desc_vld) pulses++;

  typedef struct packed {
    logic [2:0]   mode;
    logic [15:0]  thr, hyst, lo, hi, dwell;
    logic [127:0] smp;  // sample 0 in the low 16 bits
    logic [3:0]   exp;  // index of firing sample, 8 = none
  } row_t;

  localparam row_t ROWS [7] = '{
    // R2 rising: arms at 85, fires at 100
    '{3'd0, 16'd100, 16'd10, 16'd0, 16'd0, 16'd0,
      {16'd130,16'd50,16'd100,16'd99,16'd85,16'd105,16'd95,16'd120}, 4'd5},
    // R2 shallow dips never arm
    '{3'd0, 16'd100, 16'd10, 16'd0, 16'd0, 16'd0,
      {16'd100,16'd120,16'd91,16'd110,16'd95,16'd105,16'd95,16'd120}, 4'd8},
    // R3 falling: arms at 111, fires at 100
    '{3'd1, 16'd100, 16'd10, 16'd0, 16'd0, 16'd0,
      {16'd0,16'd0,16'd200,16'd100,16'd101,16'd105,16'd111,16'd90}, 4'd4},
    // R4 level
    '{3'd2, 16'd500, 16'd0, 16'd0, 16'd0, 16'd0,
      {16'd0,16'd0,16'd0,16'd600,16'd500,16'd20,16'd499,16'd10}, 4'd3},
    // R6 window out, dwell 3, interrupted run
    '{3'd3, 16'd0, 16'd0, 16'd100, 16'd200, 16'd3,
      {16'd150,16'd99,16'd201,16'd50,16'd150,16'd260,16'd250,16'd150}, 4'd6},
    // R7 window in, dwell 2, inclusive limits
    '{3'd4, 16'd0, 16'd0, 16'd100, 16'd200, 16'd2,
      {16'd0,16'd0,16'd0,16'd150,16'd200,16'd300,16'd100,16'd50}, 4'd4},
    // R6 dwell 0 acts as 1
    '{3'd3, 16'd0, 16'd0, 16'd100, 16'd200, 16'd0,
      {16'd0,16'd0,16'd0,16'd0,16'd0,16'd0,16'd201,16'd150}, 4'd1}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; smp_vld = 1'b0; arm = 1'b0; sw_trig = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_arm();
    arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
    @(negedge clk);
  endtask

  task automatic send(input logic [DW-1:0] v, input logic [TSW-1:0] t);
    smp = v; ts = t; smp_vld = 1'b1;
    @(negedge clk);
    smp_vld = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] blk [7];
    blk = '{16'd13, 16'd14, 16'd15, 16'd2000, 16'd21, 16'd22, 16'd23};

    // R1: reset state and no capture without arming
    do_reset();
    chk(desc_vld == 1'b0, "R1 desc_vld after reset", 32'(desc_vld), 0);
    chk(cfg_err == 1'b0, "R1 cfg_err after reset", 32'(cfg_err), 0);
    mode = 3'd2; thr = 16'd10; pulses = 0;
    send(16'd50, 32'd1); send(16'd60, 32'd2); idle(2);
    chk(pulses == 0, "R1 no descriptor while idle", 32'(pulses), 0);

    // trigger mode vector table
    for (int r = 0; r < 7; r++) begin
      do_reset();
      mode = ROWS[r].mode; thr = ROWS[r].thr; hyst = ROWS[r].hyst;
      lo = ROWS[r].lo; hi = ROWS[r].hi; dwell = ROWS[r].dwell;
      pre = LW'(2); post = LW'(1); holdoff = '0;
      do_arm();
      pulses = 0;
      for (int i = 0; i < 8; i++) send(ROWS[r].smp[16*i +: 16], 32'(100 + i));
      idle(2);
      chk(pulses == (ROWS[r].exp < 8 ? 1 : 0), $sformatf("R%0d_row%0d pulses", r < 2 ? 2 : (r == 2 ? 3 : (r == 3 ? 4 : (r == 5 ? 7 : 6))), r),
          32'(pulses), ROWS[r].exp < 8 ? 1 : 0);
      if (ROWS[r].exp < 8) begin
        chk(desc_ts == 32'(100 + ROWS[r].exp), $sformatf("R12 row%0d timestamp", r), desc_ts, 32'(100 + ROWS[r].exp));
        chk(desc_mode == ROWS[r].mode, $sformatf("R12 row%0d mode", r), 32'(desc_mode), 32'(ROWS[r].mode));
      end
    end

    // R9: block contents, start index and lengths
    do_reset();
    mode = 3'd2; thr = 16'd1000; pre = LW'(3); post = LW'(4); holdoff = '0;
    do_arm();
    pulses = 0;
    for (int i = 0; i < 5; i++) send(16'(11 + i), 32'(10 + i));
    send(16'd2000, 32'd77);
    chk(pulses == 0, "R12 no pulse before post ends", 32'(pulses), 0);
    send(16'd21, 32'd78); send(16'd22, 32'd79);
    chk(pulses == 0, "R12 no pulse one sample early", 32'(pulses), 0);
    smp = 16'd23; ts = 32'd80; smp_vld = 1'b1;
    @(negedge clk);
    smp_vld = 1'b0;
    chk(desc_vld == 1'b1, "R12 pulse after last post sample", 32'(desc_vld), 1);
    @(negedge clk);
    chk(desc_vld == 1'b0, "R12 pulse lasts one cycle", 32'(desc_vld), 0);
    chk(desc_ts == 32'd77, "R12 trigger timestamp", desc_ts, 77);
    chk(desc_start == AW'(2), "R9 start index", 32'(desc_start), 2);
    chk(desc_pre == LW'(3), "R9 pre length", 32'(desc_pre), 3);
    chk(desc_post == LW'(4), "R9 post length", 32'(desc_post), 4);
    chk(desc_fill == LW'(5), "R10 fill at trigger", 32'(desc_fill), 5);
    chk(desc_short == 1'b0, "R10 full pre history", 32'(desc_short), 0);
    send(16'd999, 32'd81);  // idle after capture: must not be written
    for (int k = 0; k < 7; k++) begin
      rd_addr = desc_start + AW'(k);
      @(negedge clk);
      chk(rd_data == blk[k], $sformatf("R9 block word %0d", k), 32'(rd_data), 32'(blk[k]));
    end
    rd_addr = desc_start + AW'(7);
    @(negedge clk);
    chk(rd_data != 16'd999, "R1 no write while idle", 32'(rd_data), 0);

    // R10: short pre-event history
    do_reset();
    mode = 3'd2; thr = 16'd1000; pre = LW'(4); post = LW'(2);
    do_arm();
    send(16'd5, 32'd1); send(16'd3000, 32'd2); send(16'd6, 32'd3); idle(1);
    chk(desc_short == 1'b1, "R10 short flag", 32'(desc_short), 1);
    chk(desc_pre == LW'(1), "R10 actual pre", 32'(desc_pre), 1);
    chk(desc_fill == LW'(1), "R10 fill", 32'(desc_fill), 1);

    // R5: triggers during post and holdoff are ignored
    do_reset();
    mode = 3'd2; thr = 16'd1000; pre = LW'(0); post = LW'(3); holdoff = CW'(2);
    do_arm();
    pulses = 0;
    for (int i = 1; i <= 3; i++) send(16'd2000, 32'(i));
    idle(1);
    chk(pulses == 1, "R5 one capture", 32'(pulses), 1);
    chk(desc_ts == 32'd1, "R5 post-window triggers ignored", desc_ts, 1);
    do_arm();
    for (int i = 4; i <= 8; i++) send(16'd2000, 32'(i));
    idle(1);
    chk(pulses == 2, "R5 second capture", 32'(pulses), 2);
    chk(desc_ts == 32'd6, "R5 holdoff skips two samples", desc_ts, 6);

    // R8: software trigger latched until the next sample
    do_reset();
    mode = 3'd5; pre = LW'(1); post = LW'(2); holdoff = '0;
    do_arm();
    pulses = 0;
    send(16'd5, 32'd50); send(16'd6, 32'd51); idle(1);
    chk(pulses == 0, "R8 no fire without request", 32'(pulses), 0);
    sw_trig = 1'b1;
    @(negedge clk);
    sw_trig = 1'b0;
    idle(1);
    send(16'd7, 32'd52); send(16'd8, 32'd53); idle(1);
    chk(pulses == 1, "R8 soft capture", 32'(pulses), 1);
    chk(desc_ts == 32'd52, "R8 fires on next sample", desc_ts, 52);

    // R11: length configuration errors
    do_reset();
    mode = 3'd2; thr = 16'd10; pre = LW'(800); post = LW'(300);
    @(negedge clk);
    chk(cfg_err == 1'b1, "R11 pre+post over depth", 32'(cfg_err), 1);
    do_arm();
    pulses = 0;
    send(16'd50, 32'd1); send(16'd60, 32'd2); idle(2);
    chk(pulses == 0, "R11 arm refused", 32'(pulses), 0);
    pre = LW'(4); post = LW'(0);
    @(negedge clk);
    chk(cfg_err == 1'b1, "R11 zero post", 32'(cfg_err), 1);
    pre = LW'(724); post = LW'(300);
    @(negedge clk);
    chk(cfg_err == 1'b0, "R11 exactly full depth", 32'(cfg_err), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule